// File: doc/BRIEF.md
# Control-Flow Next-PC Calculator

This block sits in the execute stage of a small 8-bit RISC core and decides where the program counter goes after a control-flow instruction. It receives the current word-address PC, the first instruction word, the word that follows it, the status byte and the 16-bit pointer register value. It classifies the instruction and computes the next PC. The instruction can be a PC-relative jump or call, a two-word absolute jump or call, a pointer-indirect jump or call, or a conditional branch on one status bit.

The results are registered. One clock after an instruction is presented with `in_valid`, the block shows the next PC and a `taken` flag. For a call it also raises `push_req` for one cycle, with the return address the return stack must store. A word that is not a control-flow instruction simply advances the PC by one. Every target is reduced modulo 2^PC_W, so it wraps inside program space.

Top module: `cf_next_pc`

## Requirements
- R1: A word with bits 15:12 = 4'hC (relative jump) or 4'hD (relative call) goes to PC + 1 + sign-extended bits 11:0, and `taken` is 1.
- R2: A word with bits 15:11 = 5'b11110 is a conditional branch. It tests status bit `insn_w0[2:0]`; bit 10 = 0 branches when that bit is 1 and bit 10 = 1 branches when it is 0. When taken the target is PC + 1 + sign-extended bits 9:3 and `taken` is 1. Otherwise the next PC is PC + 1 and `taken` is 0.
- R3: A word matching 16'h940C under mask 16'hFE0E (absolute jump), or 16'h940E under the same mask (absolute call), goes to {bits 8:4, bit 0, second word}, a 22-bit target, with `taken` 1.
- R4: Exactly 16'h9409 (indirect jump) and 16'h9509 (indirect call) replace PC bits 15:0 with `ptr_val` and keep the PC bits above bit 15, with `taken` 1.
- R5: Only calls (relative, absolute, indirect) raise `push_req`. `ret_addr` is PC + 1 for one-word calls and PC + 2 for the absolute call.
- R6: Any other word gives next PC = PC + 1, with `taken` 0 and `push_req` 0. The second word and the pointer are ignored.
- R7: Every next PC and return address is taken modulo 2^PC_W.
- R8: Outputs update on the clock edge that samples `in_valid` = 1. While `in_valid` is 0, `taken` and `push_req` read 0 and `nxt_pc` and `ret_addr` hold their values, so `push_req` lasts one cycle per call.
- R9: Synchronous active-high `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction words and operands are valid this cycle |
| cur_pc | input | PC_W | Word address of the current instruction |
| insn_w0 | input | 16 | First instruction word |
| insn_w1 | input | 16 | Following word (absolute target low half) |
| status_b | input | 8 | Status byte tested by conditional branches |
| ptr_val | input | 16 | Pointer register pair value |
| nxt_pc | output | PC_W | Registered next program counter |
| taken | output | 1 | Control flow left the sequential path |
| push_req | output | 1 | One-cycle request to push `ret_addr` |
| ret_addr | output | PC_W | Return address for a call |

## Verification
The bench targets the extreme offsets: -2048 and +2047 for relative jumps, -64 and +63 for branches, and an offset of -1 that lands on the instruction itself. A design that sign-extends wrongly or forgets the +1 base lands on the wrong word. Branches are run with both polarities and with a status byte that is set everywhere except the tested bit. This exposes a wrong bit select or an inverted bit 10. It also drives an absolute call at the top of program space, where the return address must wrap to zero, and an indirect jump whose PC has high bits set that must survive. A word that only resembles an indirect jump must fall through, and an idle cycle after a call must drop `push_req`. A design that repeats pushes or holds the wrong PC would fail these.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef enum logic [2:0] {
    CF_NONE,
    CF_REL_JMP,
    CF_REL_CALL,
    CF_BRANCH,
    CF_ABS_JMP,
    CF_ABS_CALL,
    CF_IND_JMP,
    CF_IND_CALL
  } cf_kind_e;

  localparam logic [15:0] ABS_MASK  = 16'hFE0E;
  localparam logic [15:0] ABS_JMP   = 16'h940C;
  localparam logic [15:0] ABS_CALL  = 16'h940E;
  localparam logic [15:0] IND_JMP   = 16'h9409;
  localparam logic [15:0] IND_CALL  = 16'h9509;
endpackage

// File: rtl/cf_decode.sv
module cf_decode
  import cf_pkg::*;
(
  input  logic [15:0] word,
  output cf_kind_e    kind
);
  always_comb begin
    kind = CF_NONE;
    if (word[15:12] == 4'hC)                    kind = CF_REL_JMP;   // R1
    else if (word[15:12] == 4'hD)               kind = CF_REL_CALL;  // R1
    else if (word[15:11] == 5'b11110)           kind = CF_BRANCH;    // R2
    else if ((word & ABS_MASK) == ABS_JMP)      kind = CF_ABS_JMP;   // R3
    else if ((word & ABS_MASK) == ABS_CALL)     kind = CF_ABS_CALL;  // R3
    else if (word == IND_JMP)                   kind = CF_IND_JMP;   // R4
    else if (word == IND_CALL)                  kind = CF_IND_CALL;  // R4
  end
endmodule

// File: rtl/cf_target.sv
module cf_target
  import cf_pkg::*;
#(
  parameter int PC_W = 22
) (
  input  cf_kind_e          kind,
  input  logic [PC_W-1:0]   pc,
  input  logic [15:0]       w0,
  input  logic [15:0]       w1,
  input  logic [7:0]        status,
  input  logic [15:0]       ptr,
  output logic [PC_W-1:0]   target,
  output logic              jump,
  output logic              call,
  output logic [PC_W-1:0]   ret
);
  localparam int ABS_W = 22;

  logic [PC_W-1:0] seq1, seq2, rel12, rel7, abs_t, ind_t;
  logic [ABS_W-1:0] abs_full;
  logic            cond_bit, cond_ok;

  assign seq1  = pc + PC_W'(1);
  assign seq2  = pc + PC_W'(2);
  assign rel12 = seq1 + {{(PC_W-12){w0[11]}}, w0[11:0]};
  assign rel7  = seq1 + {{(PC_W-7){w0[9]}}, w0[9:3]};

  assign abs_full = {w0[8:4], w0[0], w1};
  assign abs_t    = PC_W'(abs_full);

  generate
    if (PC_W > 16) begin : g_ind_keep_high
      assign ind_t = {pc[PC_W-1:16], ptr};
    end else begin : g_ind_narrow
      assign ind_t = ptr[PC_W-1:0];
    end
  endgenerate

  assign cond_bit = status[w0[2:0]];
  assign cond_ok  = w0[10] ? ~cond_bit : cond_bit;

  always_comb begin
    target = seq1;
    jump   = 1'b0;
    call   = 1'b0;
    ret    = seq1;
    unique case (kind)
      CF_REL_JMP:  begin target = rel12; jump = 1'b1; end
      CF_REL_CALL: begin target = rel12; jump = 1'b1; call = 1'b1; end
      CF_BRANCH:   begin
        if (cond_ok) begin target = rel7; jump = 1'b1; end
      end
      CF_ABS_JMP:  begin target = abs_t; jump = 1'b1; end
      CF_ABS_CALL: begin target = abs_t; jump = 1'b1; call = 1'b1; ret = seq2; end
      CF_IND_JMP:  begin target = ind_t; jump = 1'b1; end
      CF_IND_CALL: begin target = ind_t; jump = 1'b1; call = 1'b1; end
      default:     begin target = seq1; end
    endcase
  end
endmodule

// File: rtl/cf_next_pc.sv
module cf_next_pc
  import cf_pkg::*;
#(
  parameter int PC_W = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [15:0]     insn_w0,
  input  logic [15:0]     insn_w1,
  input  logic [7:0]      status_b,
  input  logic [15:0]     ptr_val,
  output logic [PC_W-1:0] nxt_pc,
  output logic            taken,
  output logic            push_req,
  output logic [PC_W-1:0] ret_addr
);
  cf_kind_e        kind;
  logic [PC_W-1:0] tgt, ret_c;
  logic            jmp_c, call_c;

  cf_decode u_dec (.word(insn_w0), .kind(kind));

  cf_target #(.PC_W(PC_W)) u_tgt (
    .kind(kind), .pc(cur_pc), .w0(insn_w0), .w1(insn_w1),
    .status(status_b), .ptr(ptr_val),
    .target(tgt), .jump(jmp_c), .call(call_c), .ret(ret_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_pc   <= '0;
      taken    <= 1'b0;
      push_req <= 1'b0;
      ret_addr <= '0;
    end else if (in_valid) begin
      nxt_pc   <= tgt;
      taken    <= jmp_c;
      push_req <= call_c;
      if (call_c) ret_addr <= ret_c;
    end else begin
      taken    <= 1'b0;
      push_req <= 1'b0;
    end
  end

  AST_PUSH_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    push_req |-> $past(in_valid)); // R8
  AST_PUSH_IS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    push_req |-> taken); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!taken && !push_req && $stable(nxt_pc) && $stable(ret_addr))); // R8
  AST_FALLTHROUGH_SEQ: assert property (@(posedge clk) disable iff (rst)
    in_valid && !jmp_c |=> (nxt_pc == $past(cur_pc) + PC_W'(1))); // R6
  AST_RET_AFTER_CALL: assert property (@(posedge clk) disable iff (rst)
    push_req |-> (ret_addr == $past(cur_pc) + PC_W'(1)
               || ret_addr == $past(cur_pc) + PC_W'(2))); // R5
endmodule

// File: tb/test_cf_next_pc.sv
module test_cf_next_pc;
  localparam int PC_W = 22;
  localparam int NV   = 17;

  typedef struct packed {
    logic [21:0] pc;
    logic [15:0] w0;
    logic [15:0] w1;
    logic [7:0]  st;
    logic [15:0] ptr;
    logic [21:0] nxt;
    logic        tk;
    logic        ps;
    logic [21:0] ret;
    logic [3:0]  req;
  } vec_t;

  // pc, w0, w1, status, ptr, expected next, taken, push, ret, requirement
  localparam vec_t VEC [NV] = '{
    '{22'h000100, 16'hC005, 16'h0000, 8'h00, 16'h0000, 22'h000106, 1'b1, 1'b0, 22'h0, 4'd1}, // R1 fwd
    '{22'h000100, 16'hCFFF, 16'h0000, 8'h00, 16'h0000, 22'h000100, 1'b1, 1'b0, 22'h0, 4'd1}, // R1 self
    '{22'h000010, 16'hC800, 16'h0000, 8'h00, 16'h0000, 22'h3FF811, 1'b1, 1'b0, 22'h0, 4'd7}, // R7 wrap down
    '{22'h002000, 16'hD7FF, 16'h0000, 8'h00, 16'h0000, 22'h002800, 1'b1, 1'b1, 22'h002001, 4'd5}, // R5 rcall
    '{22'h000300, 16'hF051, 16'h0000, 8'h02, 16'h0000, 22'h00030B, 1'b1, 1'b0, 22'h0, 4'd2}, // R2 set taken
    '{22'h000300, 16'hF051, 16'h0000, 8'h00, 16'h0000, 22'h000301, 1'b0, 1'b0, 22'h0, 4'd2}, // R2 not taken
    '{22'h001000, 16'hF607, 16'h0000, 8'h00, 16'h0000, 22'h000FC1, 1'b1, 1'b0, 22'h0, 4'd2}, // R2 clr -64
    '{22'h001000, 16'hF607, 16'h0000, 8'h80, 16'h0000, 22'h001001, 1'b0, 1'b0, 22'h0, 4'd2}, // R2 clr not
    '{22'h000050, 16'hF1F8, 16'h0000, 8'h01, 16'h0000, 22'h000090, 1'b1, 1'b0, 22'h0, 4'd2}, // R2 +63
    '{22'h000012, 16'h955C, 16'h1234, 8'h00, 16'h0000, 22'h2A1234, 1'b1, 1'b0, 22'h0, 4'd3}, // R3 jmp
    '{22'h3FFFFE, 16'h940F, 16'hBEEF, 8'h00, 16'h0000, 22'h01BEEF, 1'b1, 1'b1, 22'h000000, 4'd3}, // R3 call wrap
    '{22'h2ABCDE, 16'h9409, 16'h0000, 8'h00, 16'h4321, 22'h2A4321, 1'b1, 1'b0, 22'h0, 4'd4}, // R4 ijmp
    '{22'h010005, 16'h9509, 16'h0000, 8'h00, 16'hFFFF, 22'h01FFFF, 1'b1, 1'b1, 22'h010006, 4'd4}, // R4 icall
    '{22'h3FFFFF, 16'h0000, 16'hFFFF, 8'hFF, 16'hFFFF, 22'h000000, 1'b0, 1'b0, 22'h0, 4'd6}, // R6 wrap
    '{22'h000040, 16'h9419, 16'h0000, 8'h00, 16'h1234, 22'h000041, 1'b0, 1'b0, 22'h0, 4'd6}, // R6 near-miss
    '{22'h000000, 16'hC002, 16'hFFFF, 8'h00, 16'h0000, 22'h000003, 1'b1, 1'b0, 22'h0, 4'd1}, // R1 w1 ignored
    '{22'h000300, 16'hF051, 16'h0000, 8'hFD, 16'h0000, 22'h000301, 1'b0, 1'b0, 22'h0, 4'd2}  // R2 bit select
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [PC_W-1:0] cur_pc = '0;
  logic [15:0]     insn_w0 = '0, insn_w1 = '0, ptr_val = '0;
  logic [7:0]      status_b = '0;
  logic [PC_W-1:0] nxt_pc, ret_addr;
  logic            taken, push_req;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cf_next_pc #(.PC_W(PC_W)) i_cf_next_pc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cur_pc(cur_pc),
    .insn_w0(insn_w0), .insn_w1(insn_w1), .status_b(status_b), .ptr_val(ptr_val),
    .nxt_pc(nxt_pc), .taken(taken), .push_req(push_req), .ret_addr(ret_addr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic v, input vec_t t);
    @(negedge clk);
    in_valid = v;
    cur_pc   = t.pc;
    insn_w0  = t.w0;
    insn_w1  = t.w1;
    status_b = t.st;
    ptr_val  = t.ptr;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    vec_t idle;
    logic [PC_W-1:0] held;
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    check("R9", "nxt_pc", 32'(nxt_pc), 32'h0);
    check("R9", "taken", 32'(taken), 32'h0);
    check("R9", "push_req", 32'(push_req), 32'h0);
    check("R9", "ret_addr", 32'(ret_addr), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].req);
      drive(1'b1, VEC[i]);
      check(tag, "nxt_pc", 32'(nxt_pc), 32'(VEC[i].nxt));
      check(tag, "taken", 32'(taken), 32'(VEC[i].tk));
      check(VEC[i].ps ? tag : "R5", "push_req", 32'(push_req), 32'(VEC[i].ps));
      if (VEC[i].ps) check("R5", "ret_addr", 32'(ret_addr), 32'(VEC[i].ret));
    end

    // R8: a call followed by an idle cycle presenting another call word
    drive(1'b1, VEC[3]);
    check("R5", "push on rcall", 32'(push_req), 32'h1);
    held = nxt_pc;
    idle = VEC[12];
    drive(1'b0, idle);
    check("R8", "push drops when idle", 32'(push_req), 32'h0);
    check("R8", "taken drops when idle", 32'(taken), 32'h0);
    check("R8", "nxt_pc holds when idle", 32'(nxt_pc), 32'(held));
    check("R8", "ret_addr holds when idle", 32'(ret_addr), 32'h002001);

    // R9: reset mid-stream clears everything
    drive(1'b1, VEC[10]);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R9", "nxt_pc after reset", 32'(nxt_pc), 32'h0);
    check("R9", "push after reset", 32'(push_req), 32'h0);
    check("R9", "ret after reset", 32'(ret_addr), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule